// File: doc/BRIEF.md
# Flash Query Response Lane Replicator

This block forms the read data that a bank of identical parallel flash devices returns while the bank is in identification mode or in parameter-table query mode. The bank is described by three byte widths: the bank width, the width at which each device is wired, and the widest mode that device supports. Each of these widths is 1, 2 or 4. A read presents a byte offset and an access size. The block scales the offset down to a table index and fetches one byte from the query table, or one 16-bit code from the identification constants. For a wide device run in byte mode, the block widens the fetched value by repetition. It then copies the result into every device slot of the bank. When the access is wider than the bank, it packs several bank-width responses into a single word.

The table contents and the two identification codes are parameters. The read is launched by a one-cycle strobe. The result appears on a register one cycle later, together with a single-cycle valid flag, and holds until the next strobe. An illegal width combination stops elaboration.

Top module: `flash_query_replicator`

## Requirements
- R1: While `rstN` is low, `rdData` is zero and `rdValid` is low.
- R2: `rdValid` is high in exactly the cycle after each cycle in which `rdStb` is high, and is low in every other cycle.
- R3: `rdData` changes only in the cycle after a strobe. Changes to `qryMode`, `rdOffset` or `accSize` without a strobe have no effect on it.
- R4: The index used for a bank word is its byte offset shifted right by log2(BANK_W) + log2(MAX_DEV_W) - log2(DEV_W).
- R5: In query mode (`qryMode` = 1), an index of TABLE_LEN or more gives a zero table byte. Index i below TABLE_LEN gives byte i of TABLE_BYTES, which is bits [8i+7:8i].
- R6: When DEV_W is 1 and MAX_DEV_W is larger, the table byte is repeated into every byte of the device's widest word. The low DEV_W bytes of that word form the device response, so the byte appears in every byte lane of the bank.
- R7: When DEV_W equals MAX_DEV_W, the device response in query mode is the table byte zero-extended to DEV_W bytes. The device response is copied into each of the BANK_W/DEV_W device slots of the bank word.
- R8: In identification mode (`qryMode` = 0), only the low 8 bits of the index are decoded. 0 selects MFG_CODE, 1 selects PART_CODE, and any other value selects zero. The device response is the selected 16-bit code truncated or zero-extended to DEV_W bytes.
- R9: `accSize` codes 0, 1 and 2 mean 1, 2 and 4 bytes, and code 3 means 4 bytes. When the access is wider than BANK_W, bank word k is built from offset + k*BANK_W and placed at bits starting at 8*k*BANK_W. Bytes above the filled bank words are zero. When the access is not wider than BANK_W, one full bank word is returned.
- R10: When DEV_W is below MAX_DEV_W and DEV_W is not 1, a query-mode read returns zero.
- R11: A width outside {1,2,4}, DEV_W above MAX_DEV_W or BANK_W, TABLE_LEN outside 1..64, or OFFS_W outside 8..24 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStb | input | 1 | Read strobe, one cycle per read |
| qryMode | input | 1 | 1 = query table, 0 = identification codes |
| rdOffset | input | OFFS_W | Byte offset of the read |
| accSize | input | 2 | Access size code (0:1, 1:2, 2/3:4 bytes) |
| rdData | output | 32 | Registered response |
| rdValid | output | 1 | High for one cycle with new data |

## Verification
The bound checker watches the strobe-to-valid timing, the holding of data between strobes, zero returns for query indices past the table end, zero returns for undecoded identification indices on byte accesses, and the all-zero query response of unsupported narrowed configurations. These properties are checked on every cycle. Only the bench's scenarios can show the actual lane contents. The bench runs four width configurations side by side and compares against its own model. It covers byte repetition for wide parts in byte mode, zero-extended slot copies, index scaling with the low offset bits ignored, and packing of consecutive bank words.

// File: rtl/qr_pkg.sv
package qr_pkg;
  localparam int DATA_W    = 32;
  localparam int MAX_SLOTS = 4;
  localparam int MAX_TBL   = 64;

  typedef struct packed {
    logic                 load;
    logic                 qry;
    logic [MAX_SLOTS-1:0] slotEn;
  } qrStb_t;

  function automatic logic [8*MAX_TBL-1:0] defaultTable();
    logic [8*MAX_TBL-1:0] t;
    for (int i = 0; i < MAX_TBL; i++) begin
      t[8*i +: 8] = 8'(i) ^ 8'hA5;
    end
    t[8*16 +: 8] = 8'h51;
    t[8*17 +: 8] = 8'h52;
    t[8*18 +: 8] = 8'h59;
    return t;
  endfunction

  function automatic bit legalWidth(int w);
    return (w == 1) || (w == 2) || (w == 4);
  endfunction
endpackage

// File: rtl/qr_ctrl.sv
module qr_ctrl
  import qr_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStb,
  input  logic       qryMode,
  input  logic [1:0] accSize,
  output qrStb_t     stb,
  output logic       rdValid
);
  localparam int NSLOT = 4 / BANK_W;

  logic [2:0] accBytes;
  logic [2:0] nSlots;

  always_comb begin
    unique case (accSize)
      2'd0:    accBytes = 3'd1;
      2'd1:    accBytes = 3'd2;
      default: accBytes = 3'd4;
    endcase
    if (int'(accBytes) > BANK_W) nSlots = 3'(int'(accBytes) / BANK_W);
    else                         nSlots = 3'd1;
  end

  always_comb begin
    stb.load = rdStb;
    stb.qry  = qryMode;
    for (int k = 0; k < MAX_SLOTS; k++) begin
      stb.slotEn[k] = (k < NSLOT) && (3'(k) < nSlots);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdStb;
  end
endmodule

// File: rtl/qr_slot.sv
module qr_slot #(
  parameter int                     BANK_W      = 4,
  parameter int                     DEV_W       = 1,
  parameter int                     MAX_DEV_W   = 2,
  parameter int                     OFFS_W      = 12,
  parameter int                     TABLE_LEN   = 64,
  parameter logic [8*TABLE_LEN-1:0] TABLE_BYTES = '0,
  parameter logic [15:0]            MFG_CODE    = 16'h0000,
  parameter logic [15:0]            PART_CODE   = 16'h0000
) (
  input  logic                qry,
  input  logic [OFFS_W-1:0]   slotOffset,
  output logic [8*BANK_W-1:0] bankWord
);
  localparam int SHIFT = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
  localparam int NDEV  = BANK_W / DEV_W;

  logic [OFFS_W-1:0]    idx;
  logic [7:0]           tblByte;
  logic [15:0]          idCode;
  logic [8*DEV_W-1:0]   qryWord;
  logic [8*DEV_W-1:0]   idWord;
  logic [8*DEV_W-1:0]   devWord;

  assign idx = slotOffset >> SHIFT;

  always_comb begin
    tblByte = 8'h00;
    for (int i = 0; i < TABLE_LEN; i++) begin
      if (idx == OFFS_W'(i)) tblByte = TABLE_BYTES[8*i +: 8];
    end
  end

  always_comb begin
    unique case (idx[7:0])
      8'd0:    idCode = MFG_CODE;
      8'd1:    idCode = PART_CODE;
      default: idCode = 16'h0000;
    endcase
  end

  generate
    if (DEV_W == MAX_DEV_W) begin : g_native
      assign qryWord = (8*DEV_W)'(tblByte);
    end else if (DEV_W == 1) begin : g_bytemode
      logic [8*MAX_DEV_W-1:0] wideWord;
      assign wideWord = {MAX_DEV_W{tblByte}};
      assign qryWord  = wideWord[8*DEV_W-1:0];
    end else begin : g_unsup
      assign qryWord = '0;
    end

    if (DEV_W == 1) begin : g_id8
      assign idWord = idCode[7:0];
    end else begin : g_idwide
      assign idWord = (8*DEV_W)'(idCode);
    end
  endgenerate

  assign devWord  = qry ? qryWord : idWord;
  assign bankWord = {NDEV{devWord}};
endmodule

// File: rtl/qr_datapath.sv
module qr_datapath
  import qr_pkg::*;
#(
  parameter int                     BANK_W      = 4,
  parameter int                     DEV_W       = 1,
  parameter int                     MAX_DEV_W   = 2,
  parameter int                     OFFS_W      = 12,
  parameter int                     TABLE_LEN   = 64,
  parameter logic [8*TABLE_LEN-1:0] TABLE_BYTES = '0,
  parameter logic [15:0]            MFG_CODE    = 16'h0000,
  parameter logic [15:0]            PART_CODE   = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  qrStb_t            stb,
  input  logic [OFFS_W-1:0] rdOffset,
  output logic [DATA_W-1:0] rdData
);
  localparam int NSLOT = 4 / BANK_W;
  localparam int SW    = 8 * BANK_W;

  logic [SW-1:0]     slotWord [MAX_SLOTS];
  logic [DATA_W-1:0] nxtData;

  generate
    for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_slot
      if (k < NSLOT) begin : g_live
        qr_slot #(
          .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAX_DEV_W),
          .OFFS_W(OFFS_W), .TABLE_LEN(TABLE_LEN), .TABLE_BYTES(TABLE_BYTES),
          .MFG_CODE(MFG_CODE), .PART_CODE(PART_CODE)
        ) u_slot (
          .qry       (stb.qry),
          .slotOffset(rdOffset + OFFS_W'(k * BANK_W)),
          .bankWord  (slotWord[k])
        );
      end else begin : g_idle
        assign slotWord[k] = '0;
      end
    end
  endgenerate

  always_comb begin
    nxtData = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (stb.slotEn[k]) nxtData[k*SW +: SW] = slotWord[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdData <= '0;
    else if (stb.load) rdData <= nxtData;
  end
endmodule

// File: rtl/flash_query_replicator.sv
module flash_query_replicator
  import qr_pkg::*;
#(
  parameter int                     BANK_W      = 4,
  parameter int                     DEV_W       = 1,
  parameter int                     MAX_DEV_W   = 2,
  parameter int                     OFFS_W      = 12,
  parameter int                     TABLE_LEN   = 64,
  parameter logic [8*TABLE_LEN-1:0] TABLE_BYTES = qr_pkg::defaultTable(),
  parameter logic [15:0]            MFG_CODE    = 16'h5C3A,
  parameter logic [15:0]            PART_CODE   = 16'hA71E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic              qryMode,
  input  logic [OFFS_W-1:0] rdOffset,
  input  logic [1:0]        accSize,
  output logic [31:0]       rdData,
  output logic              rdValid
);
  // R11: reject illegal width combinations at elaboration
  generate
    if (!legalWidth(BANK_W) || !legalWidth(DEV_W) || !legalWidth(MAX_DEV_W)
        || DEV_W > MAX_DEV_W || DEV_W > BANK_W
        || TABLE_LEN < 1 || TABLE_LEN > MAX_TBL
        || OFFS_W < 8 || OFFS_W > 24) begin : g_bad_cfg
      $error("flash_query_replicator: illegal width parameters");
    end
  endgenerate

  qrStb_t stb;

  qr_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdStb  (rdStb),
    .qryMode(qryMode),
    .accSize(accSize),
    .stb    (stb),
    .rdValid(rdValid)
  );

  qr_datapath #(
    .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAX_DEV_W),
    .OFFS_W(OFFS_W), .TABLE_LEN(TABLE_LEN), .TABLE_BYTES(TABLE_BYTES),
    .MFG_CODE(MFG_CODE), .PART_CODE(PART_CODE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdOffset(rdOffset),
    .rdData  (rdData)
  );
endmodule

// File: rtl/qr_replicator_chk.sv
module qr_replicator_chk #(
  parameter int BANK_W    = 4,
  parameter int DEV_W     = 1,
  parameter int MAX_DEV_W = 2,
  parameter int OFFS_W    = 12,
  parameter int TABLE_LEN = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStb,
  input logic              qryMode,
  input logic [OFFS_W-1:0] rdOffset,
  input logic [1:0]        accSize,
  input logic [31:0]       rdData,
  input logic              rdValid
);
  localparam int SHIFT = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
  localparam bit UNSUP = (DEV_W < MAX_DEV_W) && (DEV_W != 1);

  logic [OFFS_W-1:0] chkIdx;
  assign chkIdx = rdOffset >> SHIFT;

  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> rdValid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> !rdValid); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(rdData)); // R3
  AST_QUERY_PAST_END: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && qryMode && accSize == 2'd0 && int'(chkIdx) >= TABLE_LEN) |=> (rdData == 32'h0)); // R5
  AST_ID_UNDECODED: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !qryMode && accSize == 2'd0 && chkIdx[7:0] > 8'd1) |=> (rdData == 32'h0)); // R8
  AST_UNSUP_QUERY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (UNSUP && rdStb && qryMode) |=> (rdData == 32'h0)); // R10
endmodule

bind flash_query_replicator qr_replicator_chk #(
  .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAX_DEV_W),
  .OFFS_W(OFFS_W), .TABLE_LEN(TABLE_LEN)
) u_chk (
  .clk(clk), .rstN(rstN), .rdStb(rdStb), .qryMode(qryMode),
  .rdOffset(rdOffset), .accSize(accSize), .rdData(rdData), .rdValid(rdValid)
);

// File: tb/flash_query_replicator_bench.sv
module flash_query_replicator_bench;
  localparam int          OW = 12;
  localparam int          TL = 40;
  localparam logic [15:0] MF = 16'h5C3A;
  localparam logic [15:0] PC = 16'hA71E;

  function automatic logic [7:0] benchByte(int i);
    return 8'((i * 29 + 7) ^ 90);
  endfunction

  function automatic logic [8*64-1:0] benchTable();
    logic [8*64-1:0] t;
    for (int i = 0; i < 64; i++) t[8*i +: 8] = benchByte(i);
    return t;
  endfunction

  localparam logic [8*TL-1:0] TBL = (8*TL)'(benchTable());

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, rdStb, qryMode;
  logic [OW-1:0] rdOffset;
  logic [1:0]    accSize;
  logic [31:0]   dA, dB, dC, dD;
  logic          vA, vB, vC, vD;

  // A: x4 bank of wide parts in byte mode; B: unsupported narrowing;
  // C: byte bank of byte parts; D: x4 bank of native x2 parts
  flash_query_replicator #(.BANK_W(4), .DEV_W(1), .MAX_DEV_W(2), .OFFS_W(OW),
    .TABLE_LEN(TL), .TABLE_BYTES(TBL), .MFG_CODE(MF), .PART_CODE(PC))
  u_flash_query_replicator (.clk(clk), .rstN(rstN), .rdStb(rdStb), .qryMode(qryMode),
    .rdOffset(rdOffset), .accSize(accSize), .rdData(dA), .rdValid(vA));
  flash_query_replicator #(.BANK_W(2), .DEV_W(2), .MAX_DEV_W(4), .OFFS_W(OW),
    .TABLE_LEN(TL), .TABLE_BYTES(TBL), .MFG_CODE(MF), .PART_CODE(PC))
  u_flash_query_replicator_b (.clk(clk), .rstN(rstN), .rdStb(rdStb), .qryMode(qryMode),
    .rdOffset(rdOffset), .accSize(accSize), .rdData(dB), .rdValid(vB));
  flash_query_replicator #(.BANK_W(1), .DEV_W(1), .MAX_DEV_W(1), .OFFS_W(OW),
    .TABLE_LEN(TL), .TABLE_BYTES(TBL), .MFG_CODE(MF), .PART_CODE(PC))
  u_flash_query_replicator_c (.clk(clk), .rstN(rstN), .rdStb(rdStb), .qryMode(qryMode),
    .rdOffset(rdOffset), .accSize(accSize), .rdData(dC), .rdValid(vC));
  flash_query_replicator #(.BANK_W(4), .DEV_W(2), .MAX_DEV_W(2), .OFFS_W(OW),
    .TABLE_LEN(TL), .TABLE_BYTES(TBL), .MFG_CODE(MF), .PART_CODE(PC))
  u_flash_query_replicator_d (.clk(clk), .rstN(rstN), .rdStb(rdStb), .qryMode(qryMode),
    .rdOffset(rdOffset), .accSize(accSize), .rdData(dD), .rdValid(vD));

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(int B, int D, int M, logic q, int off, logic [1:0] acc);
    int sh = $clog2(B) + $clog2(M) - $clog2(D);
    int ab = (acc == 2'd0) ? 1 : (acc == 2'd1) ? 2 : 4;
    int ns = (ab > B) ? ab / B : 1;
    logic [31:0] r = 0;
    for (int k = 0; k < ns; k++) begin
      int o = (off + k * B) & 12'hFFF;
      int idx = o >> sh;
      logic [31:0] dw;
      logic [31:0] bw = 0;
      if (q) begin
        logic [7:0] by = (idx < TL) ? benchByte(idx) : 8'h00;
        dw = (D < M && D != 1) ? 32'h0 : {24'h0, by};
      end else begin
        logic [15:0] c = ((idx & 255) == 0) ? MF : ((idx & 255) == 1) ? PC : 16'h0;
        dw = (D == 1) ? {24'h0, c[7:0]} : {16'h0, c};
      end
      for (int j = 0; j < B / D; j++) bw |= dw << (j * D * 8);
      r |= bw << (k * B * 8);
    end
    return r;
  endfunction

  task automatic doRead(string tag, logic q, int off, logic [1:0] acc);
    logic [31:0] hA, hB, hC, hD;
    @(negedge clk);
    qryMode = q; rdOffset = OW'(off); accSize = acc; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    check("R2", "valid A", {31'h0, vA}, 32'h1);
    check("R2", "valid C", {31'h0, vC}, 32'h1);
    check(tag, "data A", dA, model(4, 1, 2, q, off, acc));
    check(tag, "data B", dB, model(2, 2, 4, q, off, acc));
    check(tag, "data C", dC, model(1, 1, 1, q, off, acc));
    check(tag, "data D", dD, model(4, 2, 2, q, off, acc));
    hA = dA; hB = dB; hC = dC; hD = dD;
    rdOffset = ~rdOffset; qryMode = ~q; accSize = ~acc;
    @(negedge clk);
    check("R2", "valid drop B", {31'h0, vB}, 32'h0);
    check("R2", "valid drop D", {31'h0, vD}, 32'h0);
    check("R3", "hold A", dA, hA);
    check("R3", "hold B", dB, hB);
    check("R3", "hold C", dC, hC);
    check("R3", "hold D", dD, hD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; rdStb = 1'b0; qryMode = 1'b0; rdOffset = '0; accSize = 2'd0;
    repeat (3) @(negedge clk);
    rdStb = 1'b1; qryMode = 1'b1;
    @(negedge clk);
    check("R1", "reset data A", dA, 32'h0);
    check("R1", "reset data C", dC, 32'h0);
    check("R1", "reset valid A", {31'h0, vA}, 32'h0);
    check("R1", "reset valid D", {31'h0, vD}, 32'h0);
    rdStb = 1'b0;
    rstN = 1'b1;

    doRead("R6", 1'b1, 16 << 3, 2'd0);      // byte repeated across lanes
    doRead("R4", 1'b1, (16 << 3) + 7, 2'd0); // low offset bits ignored
    doRead("R5", 1'b1, 39 << 3, 2'd0);       // last table entry
    doRead("R5", 1'b1, 40 << 3, 2'd0);       // first index past the end
    doRead("R8", 1'b0, 0, 2'd0);             // manufacturer
    doRead("R8", 1'b0, 8, 2'd0);             // part code
    doRead("R8", 1'b0, 16, 2'd0);            // undecoded index
    doRead("R8", 1'b0, 2048, 2'd0);          // index 256 wraps to 0
    doRead("R10", 1'b1, 20, 2'd2);           // unsupported narrowing
    doRead("R9", 1'b0, 2, 2'd2);             // packed id words
    doRead("R9", 1'b1, 5, 2'd2);             // four packed bytes
    doRead("R9", 1'b1, 5, 2'd3);             // code 3 = 4 bytes
    doRead("R9", 1'b1, 9, 2'd1);             // two packed bytes
    doRead("R7", 1'b1, 20, 2'd1);            // zero-extended x2 copies
    doRead("R7", 1'b0, 4, 2'd0);             // x2 id copies

    for (int n = 0; n < 200; n++) begin
      logic q = 1'($urandom % 2);
      int off = ($urandom % 2 == 0) ? int'($urandom % 512) : int'($urandom % 4096);
      logic [1:0] acc = 2'($urandom % 4);
      doRead("R4/R7/R9", q, off, acc);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule